// File: doc/BRIEF.md
# Pin-Strapped Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial transceiver for designs without a processor. A data converter or a character display connects straight to it. Transmit and receive each have their own 8-bit parallel bus. There is no addressing and no shared register bus. The character format comes from five static strap inputs: parity off, even or odd parity, character length and stop-bit count. A load input either captures these straps into a register or, while it is held high, passes them straight through.

The serial timebase is a one-cycle enable, `tick16`, that pulses at sixteen times the bit rate. The receiver confirms a start bit at its middle and then samples each later bit at its centre. It moves each finished character to a buffer, updates the parity, framing and overrun flags at the same moment, and raises a ready flag. An active-low acknowledge input clears the ready flag. The transmitter has a holding register behind its shift register, so the next character can be loaded while the current one is still going out.

FSM states are TX_IDLE, TX_START, TX_DATA, TX_PARITY and TX_STOP for transmit, and RX_IDLE, RX_START, RX_DATA, RX_PARITY and RX_STOP for receive.

The transmit transitions are:
- TX_IDLE→TX_START on a tick with the holding register full.
- TX_START→TX_DATA after one bit time.
- TX_DATA→TX_PARITY, or TX_DATA→TX_STOP when parity is off, after the last data bit.
- TX_PARITY→TX_STOP after one bit time.
- TX_STOP→TX_IDLE after the stop time.

The receive transitions are:
- RX_IDLE→RX_START on a tick that sees the line low.
- RX_START→RX_DATA when the mid-bit sample is low.
- RX_START→RX_IDLE when that sample is high.
- RX_DATA→RX_PARITY, or RX_DATA→RX_STOP when parity is off, after the last data bit.
- RX_PARITY→RX_STOP after one bit time.
- RX_STOP→RX_IDLE at the middle of the stop bit.

Top module: `strap_uart`

## Requirements
- R1: While `cfg_load` is 1 the strap inputs act at once. While it is 0 the format in force is the one present when `cfg_load` was last 1, whatever the straps do.
- R2: `cfg_len` selects 00=5, 01=6, 10=7 and 11=8 data bits. Bits are sent and received LSB first, and the unused high bits of `rx_data` read 0.
- R3: A transmitted frame is laid out in `tick16` periods as follows:
  - a start bit of 0 lasting 16 ticks;
  - each data bit for 16 ticks;
  - a parity bit for 16 ticks unless `cfg_no_parity` is 1; with `cfg_even`=1 the count of ones over data and parity is even, otherwise it is odd;
  - a stop level of 1 lasting 16 ticks when `cfg_two_stop`=0, 24 ticks when `cfg_two_stop`=1 with 5-bit characters, and 32 ticks otherwise.
- R4: A one-cycle `tx_load` pulse captures `tx_data` and drops `tx_empty` in the next cycle. `tx_empty` rises again on the tick at which the character moves to the shift register and the start bit begins. `tx_done` is 1 only while the transmitter is idle, and the line is then 1.
- R5: A low line on a tick starts a start bit. It is confirmed only if the line is still low 8 ticks later. A shorter low pulse is ignored and produces no character.
- R6: At the middle of the first stop bit the character and all three error flags are updated together, and `rx_ready` rises on the next cycle. A cycle with `rx_ack_n`=0 clears `rx_ready` on the following cycle. The error flags change only when a character completes.
- R7: `err_parity` is 1 when the received parity bit differs from the parity the straps configure. It is always 0 when parity is off.
- R8: `err_frame` is 1 when the line reads 0 at the middle of the first stop bit.
- R9: `err_overrun` is 1 when a character completes while `rx_ready` is still 1, that is, before the previous character was acknowledged.
- R10: While `rx_bus_off` is 1, `rx_data` is high impedance. The buffered character reappears when `rx_bus_off` returns to 0.
- R11: After reset `tx_line`=1, `tx_empty`=1, `tx_done`=1 and `rx_ready`=0. The latched format after reset is 5 data bits, odd parity and one stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| cfg_load | input | 1 | Strap capture; transparent while 1 |
| cfg_no_parity | input | 1 | 1 = no parity bit |
| cfg_two_stop | input | 1 | 1 = two stop bits (1.5 for 5-bit characters) |
| cfg_len | input | 2 | Character length select |
| cfg_even | input | 1 | 1 = even parity, 0 = odd parity |
| tx_data | input | 8 | Transmit character |
| tx_load | input | 1 | Strobe that writes the holding register |
| tx_line | output | 1 | Serial output, 1 when idle |
| tx_empty | output | 1 | Holding register free |
| tx_done | output | 1 | Transmitter idle |
| rx_line | input | 1 | Serial input |
| rx_ack_n | input | 1 | Active-low clear of `rx_ready` |
| rx_bus_off | input | 1 | Puts `rx_data` into high impedance |
| rx_data | output | 8 | Received character |
| rx_ready | output | 1 | A character is waiting |
| err_parity | output | 1 | Parity mismatch on the last character |
| err_frame | output | 1 | Bad stop bit on the last character |
| err_overrun | output | 1 | Last character arrived before the previous one was acknowledged |

## Verification
The transmitter is checked by timing each line level against the tick count from the start edge. This catches a wrong bit order, a wrong parity sense and a wrong stop length, including the 24-tick case. The bench drives receive frames in four forms:
- clean frames, to check alignment and masking;
- frames with a flipped parity bit;
- frames with a low stop level;
- back-to-back frames without an acknowledge, to check overrun.

A short low pulse must be rejected. A frame sent in 8-bit format after the straps are changed to 5-bit with the load input low tells a latched format from a transparent one. Random formats and data, from a fixed seed, cover all length, parity and stop combinations on both paths.

// File: rtl/strap_uart_pkg.sv
package strap_uart_pkg;
    localparam int DATA_W = 8;
    localparam int BW     = $clog2(DATA_W + 1);

    typedef struct packed {
        logic       no_par;
        logic       two_stop;
        logic [1:0] len;
        logic       even;
    } frame_cfg_t;

    typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PARITY, TX_STOP} tx_state_e;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP} rx_state_e;

    function automatic logic [BW-1:0] data_bits(input logic [1:0] len);
        return BW'(5) + BW'(len);
    endfunction

    function automatic logic [DATA_W-1:0] len_mask(input logic [1:0] len);
        return (DATA_W'(1) << data_bits(len)) - DATA_W'(1);
    endfunction
endpackage

// File: rtl/strap_uart_cfg.sv
module strap_uart_cfg
    import strap_uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  frame_cfg_t pins,
    output frame_cfg_t cfg
);
    frame_cfg_t held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    held_q <= '0;
        else if (load) held_q <= pins;
    end

    assign cfg = load ? pins : held_q;
endmodule

// File: rtl/strap_uart_tx.sv
module strap_uart_tx
    import strap_uart_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  frame_cfg_t        cfg,
    input  logic [DATA_W-1:0] din,
    input  logic              load,
    output logic              line,
    output logic              empty,
    output logic              done
);
    localparam int CW = $clog2(2 * OSR + 1);

    tx_state_e         st, st_n;
    logic [DATA_W-1:0] hold_q, shift_q;
    logic              hold_full, par_q;
    logic [CW-1:0]     tcnt, stop_len;
    logic [BW-1:0]     bidx, nbits;
    logic              bit_end, start_go;

    assign nbits    = data_bits(cfg.len);
    assign stop_len = !cfg.two_stop ? CW'(OSR)
                    : (cfg.len == 2'b00 ? CW'(OSR + OSR / 2) : CW'(2 * OSR));
    assign bit_end  = tick && (tcnt == ((st == TX_STOP) ? stop_len : CW'(OSR)) - CW'(1));
    assign start_go = (st == TX_IDLE) && tick && hold_full;

    always_comb begin
        st_n = st;
        unique case (st)
            TX_IDLE:   if (start_go) st_n = TX_START;
            TX_START:  if (bit_end)  st_n = TX_DATA;
            TX_DATA:   if (bit_end && bidx == nbits - BW'(1))
                           st_n = cfg.no_par ? TX_STOP : TX_PARITY;
            TX_PARITY: if (bit_end)  st_n = TX_STOP;
            TX_STOP:   if (bit_end)  st_n = TX_IDLE;
            default:   st_n = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q    <= '0;
            shift_q   <= '0;
            hold_full <= 1'b0;
            par_q     <= 1'b0;
            tcnt      <= '0;
            bidx      <= '0;
        end else begin
            if (load) hold_q <= din;
            if (load)          hold_full <= 1'b1;
            else if (start_go) hold_full <= 1'b0;
            if (start_go) begin
                shift_q <= hold_q;
                par_q   <= cfg.even ? ^(hold_q & len_mask(cfg.len))
                                    : ~^(hold_q & len_mask(cfg.len));
                tcnt    <= '0;
                bidx    <= '0;
            end else if (tick && st != TX_IDLE) begin
                if (bit_end) begin
                    tcnt <= '0;
                    if (st == TX_DATA) begin
                        shift_q <= shift_q >> 1;
                        bidx    <= bidx + BW'(1);
                    end
                end else begin
                    tcnt <= tcnt + CW'(1);
                end
            end
        end
    end

    always_comb begin
        unique case (st)
            TX_IDLE:   line = 1'b1;
            TX_START:  line = 1'b0;
            TX_DATA:   line = shift_q[0];
            TX_PARITY: line = par_q;
            TX_STOP:   line = 1'b1;
            default:   line = 1'b1;
        endcase
    end

    assign empty = !hold_full;
    assign done  = (st == TX_IDLE);
endmodule

// File: rtl/strap_uart_rx.sv
module strap_uart_rx
    import strap_uart_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  frame_cfg_t        cfg,
    input  logic              line,
    input  logic              ack_n,
    output logic [DATA_W-1:0] buf_q,
    output logic              ready,
    output logic              perr,
    output logic              ferr,
    output logic              oerr,
    output logic              done_o
);
    localparam int CW = $clog2(OSR + 1);

    rx_state_e         st, st_n;
    logic [1:0]        sync_q;
    logic              rx_s, par_bit, sample;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     bidx, nbits;
    logic [DATA_W-1:0] shreg, aligned;
    logic              exp_par;

    assign rx_s    = sync_q[1];
    assign nbits   = data_bits(cfg.len);
    assign sample  = tick && (cnt == ((st == RX_START) ? CW'(OSR / 2 - 1) : CW'(OSR - 1)));
    assign aligned = shreg >> (BW'(DATA_W) - nbits);
    assign exp_par = cfg.even ? ^aligned : ~^aligned;
    assign done_o  = (st == RX_STOP) && sample;

    always_comb begin
        st_n = st;
        unique case (st)
            RX_IDLE:   if (tick && !rx_s) st_n = RX_START;
            RX_START:  if (sample) st_n = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:   if (sample && bidx == nbits - BW'(1))
                           st_n = cfg.no_par ? RX_STOP : RX_PARITY;
            RX_PARITY: if (sample) st_n = RX_STOP;
            RX_STOP:   if (sample) st_n = RX_IDLE;
            default:   st_n = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= 2'b11;
            cnt     <= '0;
            bidx    <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            buf_q   <= '0;
            ready   <= 1'b0;
            perr    <= 1'b0;
            ferr    <= 1'b0;
            oerr    <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], line};
            if (st == RX_IDLE)   cnt <= '0;
            else if (tick)       cnt <= sample ? '0 : cnt + CW'(1);
            if (st == RX_START && sample) bidx <= '0;
            if (st == RX_DATA && sample) begin
                shreg <= {rx_s, shreg[DATA_W-1:1]};
                bidx  <= bidx + BW'(1);
            end
            if (st == RX_PARITY && sample) par_bit <= rx_s;
            if (done_o) begin
                buf_q <= aligned;
                ferr  <= !rx_s;
                perr  <= !cfg.no_par && (par_bit != exp_par);
                oerr  <= ready && ack_n;
            end
            if (done_o)      ready <= 1'b1;
            else if (!ack_n) ready <= 1'b0;
        end
    end
endmodule

// File: rtl/strap_uart.sv
module strap_uart
    import strap_uart_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              cfg_load,
    input  logic              cfg_no_parity,
    input  logic              cfg_two_stop,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_even,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_load,
    output logic              tx_line,
    output logic              tx_empty,
    output logic              tx_done,
    input  logic              rx_line,
    input  logic              rx_ack_n,
    input  logic              rx_bus_off,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              err_parity,
    output logic              err_frame,
    output logic              err_overrun
);
    frame_cfg_t        pins, cfg;
    logic [DATA_W-1:0] rx_buf;
    logic              rx_done;

    assign pins = '{no_par: cfg_no_parity, two_stop: cfg_two_stop,
                    len: cfg_len, even: cfg_even};

    strap_uart_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .load(cfg_load), .pins(pins), .cfg(cfg)
    );

    strap_uart_tx #(.OSR(OSR)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .cfg(cfg), .din(tx_data),
        .load(tx_load), .line(tx_line), .empty(tx_empty), .done(tx_done)
    );

    strap_uart_rx #(.OSR(OSR)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .cfg(cfg), .line(rx_line),
        .ack_n(rx_ack_n), .buf_q(rx_buf), .ready(rx_ready), .perr(err_parity),
        .ferr(err_frame), .oerr(err_overrun), .done_o(rx_done)
    );

    assign rx_data = rx_bus_off ? 'z : rx_buf;
endmodule

// File: rtl/strap_uart_chk.sv
module strap_uart_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_load,
    input logic tx_empty,
    input logic tx_done,
    input logic tx_line,
    input logic rx_done,
    input logic rx_ready,
    input logic rx_ack_n,
    input logic err_parity,
    input logic err_frame,
    input logic err_overrun
);
    AST_READY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> rx_ready); // R6
    AST_READY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ack_n && !rx_done) |=> !rx_ready); // R6
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |=> ($stable(err_parity) && $stable(err_frame) && $stable(err_overrun))); // R6
    AST_NO_FALSE_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rx_ready) |=> !err_overrun); // R9
    AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !tx_empty); // R4
    AST_IDLE_MARKING: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> tx_line); // R4
endmodule

bind strap_uart strap_uart_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_load(tx_load), .tx_empty(tx_empty),
    .tx_done(tx_done), .tx_line(tx_line), .rx_done(rx_done), .rx_ready(rx_ready),
    .rx_ack_n(rx_ack_n), .err_parity(err_parity), .err_frame(err_frame),
    .err_overrun(err_overrun)
);

// File: tb/strap_uart_tb.sv
module strap_uart_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] tdiv = 2'd0;
    int         tick_cnt = 0;
    logic       tick;
    logic       cfg_load = 1'b1, cfg_no_parity = 1'b0, cfg_two_stop = 1'b0, cfg_even = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic [7:0] tx_data = 8'h00;
    logic       tx_load = 1'b0, rx_line = 1'b1, rx_ack_n = 1'b1, rx_bus_off = 1'b0;
    logic       tx_line, tx_empty, tx_done, rx_ready, err_parity, err_frame, err_overrun;
    logic [7:0] rx_data;
    int         n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;
    assign tick = (tdiv == 2'd3);
    always @(posedge clk) begin
        tdiv <= tdiv + 2'd1;
        if (tdiv == 2'd3) tick_cnt <= tick_cnt + 1;
    end

    strap_uart u_dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick), .cfg_load(cfg_load),
        .cfg_no_parity(cfg_no_parity), .cfg_two_stop(cfg_two_stop), .cfg_len(cfg_len),
        .cfg_even(cfg_even), .tx_data(tx_data), .tx_load(tx_load), .tx_line(tx_line),
        .tx_empty(tx_empty), .tx_done(tx_done), .rx_line(rx_line), .rx_ack_n(rx_ack_n),
        .rx_bus_off(rx_bus_off), .rx_data(rx_data), .rx_ready(rx_ready),
        .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] msk(input logic [1:0] len);
        return 8'hFF >> (2'd3 - len);
    endfunction
    function automatic logic parb(input logic [7:0] d, input logic [1:0] len, input logic even);
        return even ? ^(d & msk(len)) : ~^(d & msk(len));
    endfunction
    function automatic int stop_t(input logic two, input logic [1:0] len);
        return !two ? 16 : (len == 2'd0 ? 24 : 32);
    endfunction

    task automatic wait_ticks(input int n);
        int t;
        t = tick_cnt + n;
        while (tick_cnt < t) @(negedge clk);
    endtask

    task automatic drive_bit(input logic b, input int n);
        rx_line = b;
        wait_ticks(n);
    endtask

    task automatic set_cfg(input logic np, input logic two, input logic [1:0] len, input logic ev);
        @(negedge clk);
        cfg_no_parity = np; cfg_two_stop = two; cfg_len = len; cfg_even = ev; cfg_load = 1'b1;
    endtask

    task automatic send_rx(input logic [7:0] d, input logic [1:0] len, input logic np,
                           input logic ev, input logic bad_par, input logic bad_stop);
        drive_bit(1'b0, 16);
        for (int i = 0; i < 5 + int'(len); i++) drive_bit(d[i], 16);
        if (!np) drive_bit(parb(d, len, ev) ^ bad_par, 16);
        if (bad_stop) drive_bit(1'b0, 12);
        drive_bit(1'b1, 20);
    endtask

    task automatic check_rx(input logic [7:0] d, input logic [1:0] len, input logic np,
                            input logic bp, input logic bs, input logic ovr);
        chk(rx_ready == 1'b1, "R6 ready", int'(rx_ready), 1);
        chk(rx_data == (d & msk(len)), "R2 data", int'(rx_data), int'(d & msk(len)));
        chk(err_parity == (bp && !np), "R7 parity flag", int'(err_parity), int'(bp && !np));
        chk(err_frame == bs, "R8 frame flag", int'(err_frame), int'(bs));
        chk(err_overrun == ovr, "R9 overrun flag", int'(err_overrun), int'(ovr));
    endtask

    task automatic ack();
        @(negedge clk); rx_ack_n = 1'b0;
        @(negedge clk); rx_ack_n = 1'b1;
        chk(rx_ready == 1'b0, "R6 ack clears", int'(rx_ready), 0);
    endtask

    task automatic tx_frame(input logic [7:0] d, input logic [1:0] len, input logic np,
                            input logic ev, input logic two);
        int c0, nb, total;
        logic e;
        @(negedge clk); tx_data = d; tx_load = 1'b1;
        @(negedge clk); tx_load = 1'b0;
        chk(tx_empty == 1'b0, "R4 empty falls", int'(tx_empty), 0);
        while (tx_line) @(negedge clk);
        c0 = tick_cnt;
        chk(tx_empty == 1'b1, "R4 empty on transfer", int'(tx_empty), 1);
        nb = 5 + int'(len);
        for (int i = 0; i <= nb + (np ? 0 : 1); i++) begin
            e = (i == 0) ? 1'b0 : (i <= nb ? d[i-1] : parb(d, len, ev));
            while (tick_cnt < c0 + 16 * i + 8) @(negedge clk);
            chk(tx_line == e, "R3 bit value", int'(tx_line), int'(e));
        end
        while (!tx_done) @(negedge clk);
        total = tick_cnt - c0;
        chk(total == 16 * (1 + nb + (np ? 0 : 1)) + stop_t(two, len), "R3 frame length",
            total, 16 * (1 + nb + (np ? 0 : 1)) + stop_t(two, len));
        chk(tx_line == 1'b1, "R4 idle marking", int'(tx_line), 1);
    endtask

    initial begin
        #(20 * 190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [1:0] len;
        logic np, two, ev, bp;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(tx_line == 1'b1, "R11 line", int'(tx_line), 1);
        chk(tx_empty == 1'b1, "R11 empty", int'(tx_empty), 1);
        chk(tx_done == 1'b1, "R11 done", int'(tx_done), 1);
        chk(rx_ready == 1'b0, "R11 ready", int'(rx_ready), 0);

        // directed transmit: 8 bits even parity 1 stop, 5 bits no parity 1.5 stop
        set_cfg(1'b0, 1'b0, 2'd3, 1'b1);
        tx_frame(8'hA5, 2'd3, 1'b0, 1'b1, 1'b0);
        set_cfg(1'b1, 1'b1, 2'd0, 1'b0);
        tx_frame(8'h1B, 2'd0, 1'b1, 1'b0, 1'b1);
        set_cfg(1'b0, 1'b1, 2'd2, 1'b0);
        tx_frame(8'h5A, 2'd2, 1'b0, 1'b0, 1'b1);

        // R2 unused high bits read zero with 6-bit characters
        set_cfg(1'b0, 1'b0, 2'd1, 1'b1);
        send_rx(8'hFF, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0);
        check_rx(8'hFF, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        ack();

        // R7 parity error, R8 framing error
        set_cfg(1'b0, 1'b0, 2'd3, 1'b0);
        send_rx(8'h3C, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0);
        check_rx(8'h3C, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0);
        ack();
        send_rx(8'h81, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
        check_rx(8'h81, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0);
        ack();

        // R9 overrun: two characters without acknowledge, then a clean one
        send_rx(8'h11, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        send_rx(8'h22, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        check_rx(8'h22, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
        ack();
        send_rx(8'h33, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        check_rx(8'h33, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);

        // R10 bus release and return
        @(negedge clk); rx_bus_off = 1'b1;
        @(negedge clk);
        chk(rx_data !== 8'h33, "R10 bus off", int'(rx_data), 0);
        rx_bus_off = 1'b0;
        @(negedge clk);
        chk(rx_data === 8'h33, "R10 bus back", int'(rx_data), 8'h33);
        ack();

        // R5 short low pulse is rejected
        drive_bit(1'b0, 4);
        drive_bit(1'b1, 60);
        chk(rx_ready == 1'b0, "R5 glitch ignored", int'(rx_ready), 0);

        // R1 latched format survives strap change while load is low
        set_cfg(1'b1, 1'b0, 2'd3, 1'b0);
        @(negedge clk); cfg_load = 1'b0;
        cfg_len = 2'd0; cfg_no_parity = 1'b0;
        send_rx(8'hC3, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0);
        check_rx(8'hC3, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0);
        ack();
        // R1 transparent again once load is high
        set_cfg(1'b1, 1'b0, 2'd0, 1'b0);
        send_rx(8'h15, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
        check_rx(8'h15, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
        ack();

        // random formats and data on both paths
        for (int k = 0; k < 12; k++) begin
            len = 2'($urandom % 4);
            np  = 1'($urandom % 2);
            two = 1'($urandom % 2);
            ev  = 1'($urandom % 2);
            d   = 8'($urandom);
            set_cfg(np, two, len, ev);
            tx_frame(d, len, np, ev, two);
            d  = 8'($urandom);
            bp = ($urandom % 4 == 0) && !np;
            send_rx(d, len, np, ev, bp, 1'b0);
            check_rx(d, len, np, bp, 1'b0, 1'b0);
            ack();
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule